// File: doc/BRIEF.md
# Token and PID Packet Decoder

This block sits behind a serial-bus receive front end that has already undone the line coding and removed the stuffed bits. It takes the packet one byte at a time, framed by a start pulse and an end pulse. It then reports what kind of packet arrived. The first byte is the packet identifier. The identifier is accepted only when its upper nibble is the bitwise inverse of its lower nibble and the type code is not the reserved all-zero value. Each packet is classed as token, data, handshake or special.

For the three-byte token packets, the block unpacks the 11-bit field that follows the identifier. For transfer tokens this field holds a 7-bit device address and a 4-bit endpoint. For the start-of-frame token it holds a frame number. The block also checks the 5-bit CRC that closes the token. A transfer token is announced only when its address equals the programmable address of the device. A frame token is reported whatever its field holds. Length faults, CRC faults and identifier faults each raise their own flag. All results are registered and appear as one-cycle strobes in the cycle after the end pulse.

Top module: `usb_pkt_decode`

## Requirements
- R1: While reset is high and in the first cycle after it, every strobe and error flag is low.
- R2: An identifier byte is valid only if bits [7:4] equal the inverse of bits [3:0] and bits [3:0] are not 0000. A packet with an invalid identifier, or with no bytes, raises pid_err_o and no other strobe or flag.
- R3: The class is taken from the type code in bits [3:0]. Tokens are 0001, 1001, 0101, 1101 and 0100 (class 01). Handshakes are 0010, 1010, 0110 and 1110 (class 10). Data packets are 0011, 1011, 0111 and 1111 (class 11). Every other valid code is special (class 00). A packet with a valid identifier pulses pkt_done_o with pkt_class_o and pkt_pid_o, and a data packet also pulses data_vld_o.
- R4: In a token, the address is byte1[6:0] and the endpoint is {byte2[2:0], byte1[7]}. The frame number is {byte2[2:0], byte1}.
- R5: A three-byte token fails its CRC check when the CRC in byte2[7:3] does not fit the 11-bit field. The check uses generator x^5+x^2+1, a preset of all ones and an inverted CRC, sent most significant bit first. A failing token raises crc_err_o and produces no token or frame strobe.
- R6: A token packet with a byte count other than three raises len_err_o and no token or frame strobe.
- R7: A handshake of exactly one byte pulses hs_vld_o. A longer handshake raises len_err_o instead.
- R8: A good transfer token (type 0001, 1001, 1101 or 0100) pulses tok_vld_o only when its address equals dev_addr_i. A token for another address produces no strobe and no error.
- R9: A good frame token (type 0101) pulses sof_vld_o with frame_o, whatever the value of dev_addr_i.
- R10: All strobes and flags appear in the cycle after eop_i is sampled and last exactly one cycle.
- R11: A start pulse throws away any bytes collected so far, so the next packet is judged only on the bytes that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sop_i | input | 1 | Start of packet, a pulse in a cycle with no byte |
| byte_vld_i | input | 1 | byte_i carries a packet byte |
| byte_i | input | 8 | Packet byte, first byte is the identifier |
| eop_i | input | 1 | End of packet, a pulse in a cycle with no byte |
| dev_addr_i | input | 7 | Programmed device address |
| pkt_done_o | output | 1 | Packet with a valid identifier finished |
| pkt_class_o | output | 2 | Class: 00 special, 01 token, 10 handshake, 11 data |
| pkt_pid_o | output | 4 | Type code of the finished packet |
| tok_vld_o | output | 1 | Good transfer token for this device |
| sof_vld_o | output | 1 | Good frame token |
| hs_vld_o | output | 1 | Good handshake |
| data_vld_o | output | 1 | Data packet identifier seen |
| tok_addr_o | output | 7 | Token address field |
| tok_ep_o | output | 4 | Token endpoint field |
| frame_o | output | 11 | Frame number field |
| pid_err_o | output | 1 | Identifier check failed |
| len_err_o | output | 1 | Token or handshake byte count wrong |
| crc_err_o | output | 1 | Token CRC check failed |

## Verification
The assertions assume that sop_i, byte_vld_i and eop_i are never high in the same cycle. They also assume that dev_addr_i is steady in the cycle that carries eop_i. The bench keeps to both conditions. Each packet is driven as a start pulse, then its bytes, then an end pulse, each in its own cycle, and the address changes only between packets. The random stimulus mixes good tokens, flipped CRC bits, wrong byte counts, long handshakes, data packets, special and reserved identifiers, and raw random identifier bytes. Directed cases cover an aborted packet, a frame token sent to a foreign address, and the reset state.

// File: rtl/usb_dec_pkg.sv
package usb_dec_pkg;

  typedef enum logic [1:0] {
    CLS_SPECIAL = 2'b00,
    CLS_TOKEN   = 2'b01,
    CLS_HSHAKE  = 2'b10,
    CLS_DATA    = 2'b11
  } pkt_class_e;

  localparam int ADDR_W    = 7;
  localparam int EP_W      = 4;
  localparam int FIELD_W   = ADDR_W + EP_W;
  localparam int CRC_W     = 5;
  localparam int HDR_BYTES = 3;
  localparam int TOK_BITS  = FIELD_W + CRC_W;

  localparam logic [CRC_W-1:0] CRC5_POLY  = 5'b00101;
  localparam logic [CRC_W-1:0] CRC5_RESID = 5'b01100;

  localparam logic [3:0] TY_OUT   = 4'b0001;
  localparam logic [3:0] TY_IN    = 4'b1001;
  localparam logic [3:0] TY_SOF   = 4'b0101;
  localparam logic [3:0] TY_SETUP = 4'b1101;
  localparam logic [3:0] TY_PING  = 4'b0100;

  // Runs the whole token body (field then CRC) through the LFSR, first bit
  // on the wire first, and returns what is left in the register.
  function automatic logic [CRC_W-1:0] crc5_left(input logic [TOK_BITS-1:0] bits);
    logic [CRC_W-1:0] r;
    logic fb;
    r = '1;
    for (int i = 0; i < TOK_BITS; i++) begin
      fb = r[CRC_W-1] ^ bits[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC5_POLY : '0);
    end
    return r;
  endfunction

endpackage

// File: rtl/usb_byte_collect.sv
module usb_byte_collect #(
  parameter int CNT_MAX = 4,
  localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               sop_i,
  input  logic                               byte_vld_i,
  input  logic [7:0]                         byte_i,
  output logic [CNT_W-1:0]                   cnt_o,
  output logic [usb_dec_pkg::HDR_BYTES*8-1:0] hdr_o
);
  import usb_dec_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       hdr_q [HDR_BYTES];

  always_ff @(posedge clk) begin
    if (rst || sop_i) begin
      cnt_q <= '0;
    end else if (byte_vld_i && (cnt_q < CNT_W'(CNT_MAX))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar k = 0; k < HDR_BYTES; k++) begin : g_hdr
    always_ff @(posedge clk) begin
      if (rst) begin
        hdr_q[k] <= '0;
      end else if (byte_vld_i && !sop_i && (cnt_q == CNT_W'(k))) begin
        hdr_q[k] <= byte_i;
      end
    end
    assign hdr_o[k*8 +: 8] = hdr_q[k];
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/usb_pid_classify.sv
module usb_pid_classify (
  input  logic                    have_byte_i,
  input  logic [7:0]              pid_byte_i,
  output logic                    pid_ok_o,
  output usb_dec_pkg::pkt_class_e cls_o,
  output logic                    is_sof_o
);
  import usb_dec_pkg::*;

  logic [3:0] ty;
  assign ty = pid_byte_i[3:0];

  assign pid_ok_o = have_byte_i && (pid_byte_i[7:4] == ~ty) && (ty != 4'b0000);
  assign is_sof_o = (ty == TY_SOF);

  always_comb begin
    unique case (ty)
      TY_OUT, TY_IN, TY_SOF, TY_SETUP, TY_PING:     cls_o = CLS_TOKEN;
      4'b0010, 4'b1010, 4'b0110, 4'b1110:           cls_o = CLS_HSHAKE;
      4'b0011, 4'b1011, 4'b0111, 4'b1111:           cls_o = CLS_DATA;
      default:                                      cls_o = CLS_SPECIAL;
    endcase
  end

endmodule

// File: rtl/usb_tok_check.sv
module usb_tok_check (
  input  logic [7:0]                        b1_i,
  input  logic [7:0]                        b2_i,
  input  logic [usb_dec_pkg::ADDR_W-1:0]    dev_addr_i,
  output logic [usb_dec_pkg::ADDR_W-1:0]    addr_o,
  output logic [usb_dec_pkg::EP_W-1:0]      ep_o,
  output logic [usb_dec_pkg::FIELD_W-1:0]   field_o,
  output logic                              crc_ok_o,
  output logic                              match_o
);
  import usb_dec_pkg::*;

  assign field_o  = {b2_i[FIELD_W-9:0], b1_i};
  assign addr_o   = field_o[ADDR_W-1:0];
  assign ep_o     = field_o[FIELD_W-1:ADDR_W];
  assign crc_ok_o = (crc5_left({b2_i, b1_i}) == CRC5_RESID);
  assign match_o  = (addr_o == dev_addr_i);

endmodule

// File: rtl/usb_pkt_decode.sv
module usb_pkt_decode #(
  parameter int CNT_MAX = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sop_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        eop_i,
  input  logic [6:0]  dev_addr_i,
  output logic        pkt_done_o,
  output logic [1:0]  pkt_class_o,
  output logic [3:0]  pkt_pid_o,
  output logic        tok_vld_o,
  output logic        sof_vld_o,
  output logic        hs_vld_o,
  output logic        data_vld_o,
  output logic [6:0]  tok_addr_o,
  output logic [3:0]  tok_ep_o,
  output logic [10:0] frame_o,
  output logic        pid_err_o,
  output logic        len_err_o,
  output logic        crc_err_o
);
  import usb_dec_pkg::*;

  localparam int CNT_W = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0]       cnt;
  logic [HDR_BYTES*8-1:0] hdr;
  logic                   pid_ok, is_sof, crc_ok, match;
  pkt_class_e             cls;
  logic [ADDR_W-1:0]      addr;
  logic [EP_W-1:0]        ep;
  logic [FIELD_W-1:0]     field;

  usb_byte_collect #(.CNT_MAX(CNT_MAX)) u_collect (
    .clk(clk), .rst(rst), .sop_i(sop_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .cnt_o(cnt), .hdr_o(hdr)
  );

  usb_pid_classify u_pid (
    .have_byte_i(cnt != '0), .pid_byte_i(hdr[7:0]),
    .pid_ok_o(pid_ok), .cls_o(cls), .is_sof_o(is_sof)
  );

  usb_tok_check u_tok (
    .b1_i(hdr[15:8]), .b2_i(hdr[23:16]), .dev_addr_i(dev_addr_i),
    .addr_o(addr), .ep_o(ep), .field_o(field), .crc_ok_o(crc_ok), .match_o(match)
  );

  // Decisions taken in the end-of-packet cycle.
  logic tok_len_ok, tok_good, hs_len_ok;
  logic n_done, n_tok, n_sof, n_hs, n_data, n_perr, n_lerr, n_cerr;

  assign tok_len_ok = (cnt == CNT_W'(HDR_BYTES));
  assign hs_len_ok  = (cnt == CNT_W'(1));
  assign tok_good   = pid_ok && (cls == CLS_TOKEN) && tok_len_ok && crc_ok;

  always_comb begin
    n_done = eop_i && pid_ok;
    n_perr = eop_i && !pid_ok;
    n_tok  = eop_i && tok_good && !is_sof && match;
    n_sof  = eop_i && tok_good && is_sof;
    n_hs   = eop_i && pid_ok && (cls == CLS_HSHAKE) && hs_len_ok;
    n_data = eop_i && pid_ok && (cls == CLS_DATA);
    n_lerr = eop_i && pid_ok && (((cls == CLS_TOKEN) && !tok_len_ok) ||
                                 ((cls == CLS_HSHAKE) && !hs_len_ok));
    n_cerr = eop_i && pid_ok && (cls == CLS_TOKEN) && tok_len_ok && !crc_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_done_o <= 1'b0;
      tok_vld_o  <= 1'b0;
      sof_vld_o  <= 1'b0;
      hs_vld_o   <= 1'b0;
      data_vld_o <= 1'b0;
      pid_err_o  <= 1'b0;
      len_err_o  <= 1'b0;
      crc_err_o  <= 1'b0;
      pkt_class_o <= '0;
      pkt_pid_o   <= '0;
      tok_addr_o  <= '0;
      tok_ep_o    <= '0;
      frame_o     <= '0;
    end else begin
      pkt_done_o <= n_done;
      tok_vld_o  <= n_tok;
      sof_vld_o  <= n_sof;
      hs_vld_o   <= n_hs;
      data_vld_o <= n_data;
      pid_err_o  <= n_perr;
      len_err_o  <= n_lerr;
      crc_err_o  <= n_cerr;
      if (eop_i) begin
        pkt_class_o <= cls;
        pkt_pid_o   <= hdr[3:0];
        tok_addr_o  <= addr;
        tok_ep_o    <= ep;
        frame_o     <= field;
      end
    end
  end

  // Guards: inputs never raise sop/byte/eop together; dev_addr_i steady at eop.
  a_r2_pid_err_alone: assert property (@(posedge clk) disable iff (rst)
    pid_err_o |-> !(pkt_done_o || tok_vld_o || sof_vld_o || hs_vld_o ||
                    data_vld_o || len_err_o || crc_err_o));

  a_r10_after_eop: assert property (@(posedge clk) disable iff (rst)
    (pkt_done_o || pid_err_o) |-> $past(eop_i));

  a_r3_one_kind: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tok_vld_o, sof_vld_o, hs_vld_o, data_vld_o}));

  a_r8_addr_match: assert property (@(posedge clk) disable iff (rst)
    tok_vld_o |-> (tok_addr_o == $past(dev_addr_i)));

  a_r5_crc_blocks: assert property (@(posedge clk) disable iff (rst)
    crc_err_o |-> !(tok_vld_o || sof_vld_o || len_err_o));

  a_r6_len_blocks: assert property (@(posedge clk) disable iff (rst)
    len_err_o |-> !(tok_vld_o || sof_vld_o || hs_vld_o));

endmodule

// File: tb/usb_pkt_decode_tb_top.sv
module usb_pkt_decode_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sop_i = 1'b0, byte_vld_i = 1'b0, eop_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic [6:0]  dev_addr_i = 7'h05;
  logic        pkt_done_o, tok_vld_o, sof_vld_o, hs_vld_o, data_vld_o;
  logic        pid_err_o, len_err_o, crc_err_o;
  logic [1:0]  pkt_class_o;
  logic [3:0]  pkt_pid_o, tok_ep_o;
  logic [6:0]  tok_addr_o;
  logic [10:0] frame_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  usb_pkt_decode dut_i (
    .clk(clk), .rst(rst), .sop_i(sop_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .eop_i(eop_i), .dev_addr_i(dev_addr_i), .pkt_done_o(pkt_done_o),
    .pkt_class_o(pkt_class_o), .pkt_pid_o(pkt_pid_o), .tok_vld_o(tok_vld_o),
    .sof_vld_o(sof_vld_o), .hs_vld_o(hs_vld_o), .data_vld_o(data_vld_o),
    .tok_addr_o(tok_addr_o), .tok_ep_o(tok_ep_o), .frame_o(frame_o),
    .pid_err_o(pid_err_o), .len_err_o(len_err_o), .crc_err_o(crc_err_o)
  );

  typedef struct packed {
    logic       done, tok, sof, hs, dat, perr, lerr, cerr;
    logic [1:0] cls;
    logic [3:0] pid;
    logic [6:0] addr;
    logic [3:0] ep;
    logic [10:0] frm;
  } exp_t;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Forward CRC5 of the 11-bit field, returned as it sits in byte2[7:3].
  function automatic logic [4:0] crc_field(input logic [10:0] f);
    logic [4:0] c;
    logic fb;
    c = 5'h1f;
    for (int i = 0; i < 11; i++) begin
      fb = c[4] ^ f[i];
      c  = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'b00101;
    end
    c = ~c;
    return {c[0], c[1], c[2], c[3], c[4]};
  endfunction

  function automatic exp_t model(input int n, input logic [7:0] b0, input logic [7:0] b1,
                                 input logic [7:0] b2, input logic [6:0] dev);
    exp_t e;
    logic [3:0] t;
    bit ok, crc_good;
    e = '0;
    t = b0[3:0];
    ok = (n >= 1) && (b0[7:4] == ~t) && (t != 4'd0);
    e.pid = t;
    e.addr = b1[6:0];
    e.ep = {b2[2:0], b1[7]};
    e.frm = {b2[2:0], b1};
    if (!ok) begin
      e.perr = 1'b1;
      return e;
    end
    e.done = 1'b1;
    crc_good = (b2[7:3] == crc_field({b2[2:0], b1}));
    if (t == 4'b0001 || t == 4'b1001 || t == 4'b0101 || t == 4'b1101 || t == 4'b0100) begin
      e.cls = 2'b01;
      e.lerr = (n != 3);
      e.cerr = (n == 3) && !crc_good;
      if (n == 3 && crc_good) begin
        if (t == 4'b0101) e.sof = 1'b1;
        else e.tok = (b1[6:0] == dev);
      end
    end else if (t[1:0] == 2'b10) begin
      e.cls = 2'b10;
      e.hs = (n == 1);
      e.lerr = (n != 1);
    end else if (t[1:0] == 2'b11) begin
      e.cls = 2'b11;
      e.dat = 1'b1;
    end else begin
      e.cls = 2'b00;
    end
    return e;
  endfunction

  task automatic send(input int n, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2, input logic [7:0] bx);
    @(negedge clk) sop_i = 1'b1;
    @(negedge clk) sop_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_vld_i = 1'b1;
      byte_i = (i == 0) ? b0 : (i == 1) ? b1 : (i == 2) ? b2 : bx;
      @(negedge clk);
    end
    byte_vld_i = 1'b0;
    eop_i = 1'b1;
    @(negedge clk) eop_i = 1'b0;
  endtask

  task automatic compare(input exp_t e);
    logic [7:0] act_s, exp_s;
    act_s = {pkt_done_o, tok_vld_o, sof_vld_o, hs_vld_o, data_vld_o, pid_err_o, len_err_o, crc_err_o};
    exp_s = {e.done, e.tok, e.sof, e.hs, e.dat, e.perr, e.lerr, e.cerr};
    chk(act_s == exp_s, "R2/R3/R5/R6/R7/R8/R9 strobes", 32'(act_s), 32'(exp_s));
    if (e.done)
      chk({pkt_class_o, pkt_pid_o} == {e.cls, e.pid}, "R3 class/pid",
          32'({pkt_class_o, pkt_pid_o}), 32'({e.cls, e.pid}));
    if (e.tok)
      chk({tok_addr_o, tok_ep_o} == {e.addr, e.ep}, "R4 addr/ep",
          32'({tok_addr_o, tok_ep_o}), 32'({e.addr, e.ep}));
    if (e.sof)
      chk(frame_o == e.frm, "R4 frame", 32'(frame_o), 32'(e.frm));
    @(negedge clk);
    act_s = {pkt_done_o, tok_vld_o, sof_vld_o, hs_vld_o, data_vld_o, pid_err_o, len_err_o, crc_err_o};
    chk(act_s == 8'h00, "R10 single cycle", 32'(act_s), 32'h0);
  endtask

  task automatic run(input int n, input logic [7:0] b0, input logic [7:0] b1,
                     input logic [7:0] b2, input logic [7:0] bx);
    send(n, b0, b1, b2, bx);
    compare(model(n, b0, b1, b2, dev_addr_i));
  endtask

  function automatic logic [7:0] pidb(input logic [3:0] t);
    return {~t, t};
  endfunction

  initial begin
    logic [3:0] tok_ty [5];
    logic [3:0] hs_ty [4];
    logic [10:0] f;
    logic [7:0] b1, b2;
    tok_ty = '{4'b0001, 4'b1001, 4'b0101, 4'b1101, 4'b0100};
    hs_ty  = '{4'b0010, 4'b1010, 4'b0110, 4'b1110};
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    chk({pkt_done_o, tok_vld_o, sof_vld_o, hs_vld_o, data_vld_o, pid_err_o, len_err_o, crc_err_o} == 8'h0,
        "R1 reset", 32'({pkt_done_o, tok_vld_o, sof_vld_o, hs_vld_o, data_vld_o, pid_err_o, len_err_o, crc_err_o}), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk({pkt_done_o, tok_vld_o, pid_err_o} == 3'b0, "R1 after reset",
        32'({pkt_done_o, tok_vld_o, pid_err_o}), 32'h0);

    // R8: IN token to address 5, endpoint 9.
    f = {4'd9, 7'd5};
    run(3, pidb(4'b1001), f[7:0], {crc_field(f), f[10:8]}, 8'h00);
    chk(1'b1, "R8 directed token", 0, 0);
    // R8: same token for another device is silent.
    f = {4'd9, 7'd6};
    run(3, pidb(4'b1001), f[7:0], {crc_field(f), f[10:8]}, 8'h00);
    // R9: frame token whose field does not match dev_addr_i.
    f = 11'h7ff;
    run(3, pidb(4'b0101), f[7:0], {crc_field(f), f[10:8]}, 8'h00);
    chk(frame_o == 11'h7ff, "R9 frame held", 32'(frame_o), 32'h7ff);
    // R2: reserved type and zero-byte packet.
    run(1, 8'hF0, 8'h00, 8'h00, 8'h00);
    run(0, 8'h00, 8'h00, 8'h00, 8'h00);
    // R7: long handshake.
    run(2, pidb(4'b0010), 8'h11, 8'h00, 8'h00);
    // R11: aborted packet then a clean ACK.
    @(negedge clk) sop_i = 1'b1;
    @(negedge clk) sop_i = 1'b0; byte_vld_i = 1'b1; byte_i = 8'hA5;
    @(negedge clk) byte_i = 8'h3C;
    @(negedge clk) byte_vld_i = 1'b0;
    run(1, pidb(4'b0010), 8'h00, 8'h00, 8'h00);
    chk(1'b1, "R11 abort exercised", 0, 0);

    for (int it = 0; it < 400; it++) begin
      int kind, n;
      logic [7:0] b0;
      dev_addr_i = 7'($urandom);
      kind = $urandom % 8;
      f = 11'($urandom);
      if ($urandom % 2) f[6:0] = dev_addr_i;
      b1 = f[7:0];
      b2 = {crc_field(f), f[10:8]};
      b0 = pidb(tok_ty[$urandom % 5]);
      n = 3;
      case (kind)
        0, 1: ;
        2: b2[3 + ($urandom % 5)] ^= 1'b1;
        3: n = ($urandom % 2) ? 2 : 4;
        4: begin b0 = pidb(hs_ty[$urandom % 4]); n = ($urandom % 4 == 0) ? 2 : 1; end
        5: begin b0 = pidb({2'($urandom), 2'b11}); n = 1 + $urandom % 5; end
        6: begin b0 = ($urandom % 2) ? 8'h3C : 8'h1E; n = 1 + $urandom % 3; end
        default: begin b0 = 8'($urandom); n = 1 + $urandom % 3; end
      endcase
      run(n, b0, b1, b2, 8'($urandom));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule